// File: doc/BRIEF.md
# Exception Pending/Active State Controller

This block holds the lifecycle state of every exception source of a small processor core and picks which one the core should take next. Each source is either inactive, pending, active, or active with a fresh request waiting. Requests arrive as one-cycle hardware strobes (non-maskable interrupt, hard fault, usage fault, supervisor call, debug monitor, timer reaching zero, peripheral interrupt lines) or as software set-pending bits. Configurable sources carry an enable bit and a programmable priority. The non-maskable interrupt and the hard fault have fixed levels above every configurable one, and no enable gates them.

The chosen exception is offered to the core on a valid/ready pair (`take_valid`, `take_ready`, `take_num`). The core accepts by raising `take_ready` while `take_valid` is high. The block never stalls the core. If a more urgent source becomes pending before acceptance, the offer may switch to it, so `take_num` is only guaranteed in the cycle of acceptance. An accepted exception becomes active, and its level is pushed onto a nesting stack. The core signals `handler_exit` when the innermost handler returns. The stack is then popped, the execution level falls back to the one below, and arbitration pauses for one cycle. The execution level is the most urgent active level, or the idle level when nothing runs.

Top module: `exc_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, all pending and active bits are 0, `take_valid` is 0 and `exec_level` is all ones (idle).
- R2: A hardware strobe or a `sw_set_pend` bit for a source sets its pending bit at the next clock edge. The bit stays set until that source is accepted. Numbering: 0 NMI, 1 hard fault, 2 usage fault, 3 supervisor call, 4 debug monitor, 5 pendable service request (software only), 6 timer zero, 7+k peripheral line k.
- R3: `take_valid` is high only when some enabled pending source has a level strictly below `exec_level`. `take_num` is then the pending enabled source with the lowest level, and ties go to the lower number. Levels: NMI 0, hard fault 1, configurable source c = its PRIO_W-bit priority + 2. Source number n uses priority field c = n-2, bits [c*PRIO_W +: PRIO_W] of `src_prio`, and enable bit c of `src_enable`.
- R4: On acceptance (`take_valid && take_ready && !handler_exit`), at the next edge the source's pending bit clears, its active bit sets, and `exec_level` becomes its level.
- R5: A request for a source that is already active sets its pending bit as well (active and pending). The source is not offered again while its own level is the execution level.
- R6: NMI and hard fault ignore `src_enable` and outrank every configurable source. A pending NMI preempts a running hard fault. Nothing is offered while NMI is active.
- R7: A configurable source whose enable bit is 0 keeps its pending bit but is never offered. It is offered once enabled.
- R8: Nesting: each acceptance stacks the new level. Each `handler_exit` clears the innermost active bit and restores the previous `exec_level`. The number of active bits always equals the nesting depth.
- R9: In the cycle after a `handler_exit` that pops a handler, `take_valid` is 0. Arbitration resumes the cycle after.
- R10: When an active-and-pending source exits, it is left pending only and is offered again once its level is more urgent than the restored execution level.
- R11: `handler_exit` with nothing active changes no state and does not suppress the next offer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_req | input | 1 | Non-maskable interrupt request strobe |
| hard_fault | input | 1 | Hard fault strobe |
| usage_fault | input | 1 | Usage fault strobe |
| svc_call | input | 1 | Supervisor call strobe |
| dbg_mon_req | input | 1 | Debug monitor request strobe |
| tick_zero | input | 1 | System timer reached zero |
| irq_req | input | NUM_IRQ | Peripheral interrupt strobes |
| sw_set_pend | input | 7+NUM_IRQ | Software set-pending strobes, one per source |
| src_enable | input | 5+NUM_IRQ | Enable per configurable source |
| src_prio | input | (5+NUM_IRQ)*PRIO_W | Priority per configurable source, lower is more urgent |
| take_ready | input | 1 | Core accepts the offered exception |
| handler_exit | input | 1 | Innermost handler returns |
| take_valid | output | 1 | An exception is offered |
| take_num | output | clog2(7+NUM_IRQ) | Offered exception number |
| exc_pending | output | 7+NUM_IRQ | Pending bit per source |
| exc_active | output | 7+NUM_IRQ | Active bit per source |
| exec_level | output | PRIO_W+2 | Current execution level, all ones when idle |

## Verification
The bench builds the block with NUM_IRQ = 2 and PRIO_W = 2. This gives nine sources, four configurable levels and a nesting stack six deep. At this size every ordered pair of sources, including a source paired with itself, can be raised together under four rotated priority assignments. Each pair is then taken, drained and compared against a winner computed arithmetically in the bench. Directed sequences nest four levels deep, where NMI blocks a fault. They also cover a timer source that is active and pending at once, a disabled debug monitor, and an exit with nothing running.

// File: rtl/exc_ctrl_pkg.sv
package exc_ctrl_pkg;
  // Fixed exception numbering; arbitration ties fall to the lower number.
  localparam int EXC_NMI    = 0;
  localparam int EXC_HARD   = 1;
  localparam int EXC_USAGE  = 2;
  localparam int EXC_SVC    = 3;
  localparam int EXC_DBGMON = 4;
  localparam int EXC_SVREQ  = 5;
  localparam int EXC_TICK   = 6;
  localparam int EXC_IRQ0   = 7;
  // Number of sources with a fixed level (NMI, hard fault).
  localparam int N_FIXED    = 2;
endpackage

// File: rtl/exc_src_state.sv
module exc_src_state #(
  parameter int N_EXC = 9,
  parameter int NUM_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EXC-1:0] set_req,
  input  logic             enter,
  input  logic [NUM_W-1:0] enter_num,
  input  logic             leave,
  input  logic [NUM_W-1:0] leave_num,
  output logic [N_EXC-1:0] pending,
  output logic [N_EXC-1:0] active
);
  for (genvar g = 0; g < N_EXC; g++) begin : g_src
    logic hit_enter;
    logic hit_leave;
    assign hit_enter = enter && (enter_num == NUM_W'(g));
    assign hit_leave = leave && (leave_num == NUM_W'(g));

    // A new request wins over the clear of an entry in the same cycle.
    always_ff @(posedge clk) begin
      if (rst) begin
        pending[g] <= 1'b0;
      end else if (set_req[g]) begin
        pending[g] <= 1'b1;
      end else if (hit_enter) begin
        pending[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        active[g] <= 1'b0;
      end else if (hit_enter) begin
        active[g] <= 1'b1;
      end else if (hit_leave) begin
        active[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
  parameter int N_EXC = 9,
  parameter int NUM_W = 4,
  parameter int EP_W  = 4
) (
  input  logic [N_EXC-1:0]      eligible,
  input  logic [N_EXC*EP_W-1:0] lvl_flat,
  input  logic [EP_W-1:0]       ceiling,
  output logic                  found,
  output logic [NUM_W-1:0]      win_num,
  output logic [EP_W-1:0]       win_lvl
);
  logic [EP_W-1:0]  best;
  logic [NUM_W-1:0] best_idx;
  logic             any;

  // Linear scan from low numbers: strict compare keeps the lower number on ties.
  always_comb begin
    best     = '1;
    best_idx = '0;
    any      = 1'b0;
    for (int i = 0; i < N_EXC; i++) begin
      if (eligible[i] && (lvl_flat[i*EP_W +: EP_W] < best)) begin
        best     = lvl_flat[i*EP_W +: EP_W];
        best_idx = NUM_W'(i);
        any      = 1'b1;
      end
    end
  end

  assign found   = any && (best < ceiling);
  assign win_num = best_idx;
  assign win_lvl = best;
endmodule

// File: rtl/exc_nest_stack.sv
module exc_nest_stack #(
  parameter int DEPTH = 6,
  parameter int NUM_W = 4,
  parameter int EP_W  = 4,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [NUM_W-1:0] push_num,
  input  logic [EP_W-1:0]  push_lvl,
  input  logic             pop,
  output logic [NUM_W-1:0] top_num,
  output logic [EP_W-1:0]  top_lvl,
  output logic [CNT_W-1:0] count
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [NUM_W-1:0] num_q [DEPTH];
  logic [EP_W-1:0]  lvl_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;

  assign wr_idx = IDX_W'(cnt_q);
  assign rd_idx = IDX_W'(cnt_q - CNT_W'(1));

  // Push only ever follows a strictly more urgent level, so the depth
  // never exceeds the number of distinct levels.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (push) begin
      num_q[wr_idx] <= push_num;
      lvl_q[wr_idx] <= push_lvl;
      cnt_q         <= cnt_q + CNT_W'(1);
    end else if (pop && (cnt_q != '0)) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign top_num = (cnt_q == '0) ? '0 : num_q[rd_idx];
  assign top_lvl = (cnt_q == '0) ? '1 : lvl_q[rd_idx];
  assign count   = cnt_q;
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_ctrl_pkg::*;
#(
  parameter int NUM_IRQ = 4,
  parameter int PRIO_W  = 3
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     nmi_req,
  input  logic                                     hard_fault,
  input  logic                                     usage_fault,
  input  logic                                     svc_call,
  input  logic                                     dbg_mon_req,
  input  logic                                     tick_zero,
  input  logic [NUM_IRQ-1:0]                       irq_req,
  input  logic [EXC_IRQ0+NUM_IRQ-1:0]              sw_set_pend,
  input  logic [EXC_IRQ0+NUM_IRQ-N_FIXED-1:0]      src_enable,
  input  logic [(EXC_IRQ0+NUM_IRQ-N_FIXED)*PRIO_W-1:0] src_prio,
  input  logic                                     take_ready,
  input  logic                                     handler_exit,
  output logic                                     take_valid,
  output logic [$clog2(EXC_IRQ0+NUM_IRQ)-1:0]      take_num,
  output logic [EXC_IRQ0+NUM_IRQ-1:0]              exc_pending,
  output logic [EXC_IRQ0+NUM_IRQ-1:0]              exc_active,
  output logic [PRIO_W+1:0]                        exec_level
);
  localparam int N_EXC = EXC_IRQ0 + NUM_IRQ;
  localparam int N_CFG = N_EXC - N_FIXED;
  localparam int NUM_W = $clog2(N_EXC);
  localparam int EP_W  = PRIO_W + 2;
  localparam int DEPTH = (1 << PRIO_W) + N_FIXED;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [N_EXC-1:0]      hw_req;
  logic [N_EXC-1:0]      set_req;
  logic [N_EXC-1:0]      src_en_all;
  logic [N_EXC*EP_W-1:0] lvl_flat;
  logic                  found;
  logic [NUM_W-1:0]      win_num;
  logic [EP_W-1:0]       win_lvl;
  logic [NUM_W-1:0]      top_num;
  logic [EP_W-1:0]       top_lvl;
  logic [CNT_W-1:0]      nest_depth;
  logic                  exit_ok;
  logic                  settle_q;
  logic                  accept;

  // Hardware request map; the pendable service request has no wire.
  assign hw_req[EXC_NMI]    = nmi_req;
  assign hw_req[EXC_HARD]   = hard_fault;
  assign hw_req[EXC_USAGE]  = usage_fault;
  assign hw_req[EXC_SVC]    = svc_call;
  assign hw_req[EXC_DBGMON] = dbg_mon_req;
  assign hw_req[EXC_SVREQ]  = 1'b0;
  assign hw_req[EXC_TICK]   = tick_zero;
  assign hw_req[N_EXC-1:EXC_IRQ0] = irq_req;
  assign set_req = hw_req | sw_set_pend;

  // Level per source: fixed levels first, then programmable ones offset by 2.
  for (genvar s = 0; s < N_EXC; s++) begin : g_lvl
    if (s < N_FIXED) begin : g_fixed
      assign lvl_flat[s*EP_W +: EP_W] = EP_W'(s);
      assign src_en_all[s]            = 1'b1;
    end else begin : g_cfg
      assign lvl_flat[s*EP_W +: EP_W] =
        EP_W'(src_prio[(s-N_FIXED)*PRIO_W +: PRIO_W]) + EP_W'(N_FIXED);
      assign src_en_all[s]            = src_enable[s-N_FIXED];
    end
  end

  exc_src_state #(
    .N_EXC(N_EXC),
    .NUM_W(NUM_W)
  ) u_state (
    .clk      (clk),
    .rst      (rst),
    .set_req  (set_req),
    .enter    (accept),
    .enter_num(win_num),
    .leave    (exit_ok),
    .leave_num(top_num),
    .pending  (exc_pending),
    .active   (exc_active)
  );

  exc_arbiter #(
    .N_EXC(N_EXC),
    .NUM_W(NUM_W),
    .EP_W (EP_W)
  ) u_arb (
    .eligible(exc_pending & src_en_all),
    .lvl_flat(lvl_flat),
    .ceiling (exec_level),
    .found   (found),
    .win_num (win_num),
    .win_lvl (win_lvl)
  );

  exc_nest_stack #(
    .DEPTH(DEPTH),
    .NUM_W(NUM_W),
    .EP_W (EP_W),
    .CNT_W(CNT_W)
  ) u_stack (
    .clk     (clk),
    .rst     (rst),
    .push    (accept),
    .push_num(win_num),
    .push_lvl(win_lvl),
    .pop     (exit_ok),
    .top_num (top_num),
    .top_lvl (top_lvl),
    .count   (nest_depth)
  );

  assign exec_level = (nest_depth == '0) ? '1 : top_lvl;
  assign exit_ok    = handler_exit && (nest_depth != '0);

  // One quiet cycle after a real exit so the restored level settles.
  always_ff @(posedge clk) begin
    if (rst) settle_q <= 1'b0;
    else     settle_q <= exit_ok;
  end

  assign take_valid = found && !settle_q;
  assign take_num   = win_num;
  assign accept     = take_valid && take_ready && !handler_exit;
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
  parameter int N_EXC = 9,
  parameter int NUM_W = 4,
  parameter int EP_W  = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             take_valid,
  input logic             take_ready,
  input logic [NUM_W-1:0] take_num,
  input logic             handler_exit,
  input logic [N_EXC-1:0] exc_pending,
  input logic [N_EXC-1:0] exc_active,
  input logic [EP_W-1:0]  exec_level,
  input logic [CNT_W-1:0] nest_depth,
  input logic [NUM_W-1:0] top_num
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (exc_pending == '0 && exc_active == '0 && !take_valid));

  p_offer_pending_r3: assert property (@(posedge clk) disable iff (rst)
    take_valid |-> exc_pending[take_num]);

  p_accept_active_r4: assert property (@(posedge clk) disable iff (rst)
    (take_valid && take_ready && !handler_exit) |=> exc_active[$past(take_num)]);

  p_nmi_alone_r6: assert property (@(posedge clk) disable iff (rst)
    exc_active[0] |-> !take_valid);

  p_depth_match_r8: assert property (@(posedge clk) disable iff (rst)
    $countones(exc_active) == int'(nest_depth));

  p_exit_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (handler_exit && nest_depth != '0) |=> !take_valid);

  p_exit_keeps_pend_r10: assert property (@(posedge clk) disable iff (rst)
    (handler_exit && nest_depth != '0 && exc_pending[top_num])
      |=> (exc_pending[$past(top_num)] && !exc_active[$past(top_num)]));

  p_empty_exit_r11: assert property (@(posedge clk) disable iff (rst)
    (handler_exit && nest_depth == '0 && !take_valid)
      |=> ($stable(exc_active) && nest_depth == '0));
endmodule

bind exc_ctrl exc_ctrl_chk #(
  .N_EXC(N_EXC),
  .NUM_W(NUM_W),
  .EP_W (EP_W),
  .CNT_W(CNT_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .take_valid  (take_valid),
  .take_ready  (take_ready),
  .take_num    (take_num),
  .handler_exit(handler_exit),
  .exc_pending (exc_pending),
  .exc_active  (exc_active),
  .exec_level  (exec_level),
  .nest_depth  (nest_depth),
  .top_num     (top_num)
);

// File: tb/tb_exc_ctrl.sv
module tb_exc_ctrl;
  localparam int NIRQ = 2;
  localparam int PW   = 2;
  localparam int NE   = 7 + NIRQ;
  localparam int NC   = NE - 2;
  localparam int NW   = $clog2(NE);
  localparam int IDLE = (1 << (PW + 2)) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nmi_req = 0, hard_fault = 0, usage_fault = 0, svc_call = 0;
  logic dbg_mon_req = 0, tick_zero = 0;
  logic [NIRQ-1:0] irq_req = '0;
  logic [NE-1:0]   sw_set_pend = '0;
  logic [NC-1:0]   src_enable = '1;
  logic [NC*PW-1:0] src_prio = '0;
  logic take_ready = 0, handler_exit = 0;
  logic take_valid;
  logic [NW-1:0] take_num;
  logic [NE-1:0] exc_pending, exc_active;
  logic [PW+1:0] exec_level;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  int prio_a [NC];

  always #4 clk = ~clk;

  exc_ctrl #(.NUM_IRQ(NIRQ), .PRIO_W(PW)) dut (
    .clk(clk), .rst(rst), .nmi_req(nmi_req), .hard_fault(hard_fault),
    .usage_fault(usage_fault), .svc_call(svc_call), .dbg_mon_req(dbg_mon_req),
    .tick_zero(tick_zero), .irq_req(irq_req), .sw_set_pend(sw_set_pend),
    .src_enable(src_enable), .src_prio(src_prio), .take_ready(take_ready),
    .handler_exit(handler_exit), .take_valid(take_valid), .take_num(take_num),
    .exc_pending(exc_pending), .exc_active(exc_active), .exec_level(exec_level)
  );

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    chk(act == exp, req, what, act, exp);
  endtask

  function automatic int lvl(input int n);
    if (n == 0) return 0;
    if (n == 1) return 1;
    return prio_a[n-2] + 2;
  endfunction

  task automatic apply_prio();
    for (int c = 0; c < NC; c++) src_prio[c*PW +: PW] = prio_a[c][PW-1:0];
  endtask

  task automatic accept_one();
    take_ready = 1; cyc(); take_ready = 0;
  endtask

  task automatic exit_one();
    handler_exit = 1; cyc(); handler_exit = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NC; c++) prio_a[c] = 0;
    apply_prio();
    #2;
    repeat (3) cyc();
    // R1: state while and after reset
    chk_eq("R1", "pending in reset", int'(exc_pending), 0);
    rst = 0;
    chk_eq("R1", "active after reset", int'(exc_active), 0);
    chk_eq("R1", "take_valid after reset", int'(take_valid), 0);
    chk_eq("R1", "exec_level idle", int'(exec_level), IDLE);

    // R2 R3 R4: every ordered pair under rotated priorities
    for (int k = 0; k < 4; k++) begin
      for (int c = 0; c < NC; c++) prio_a[c] = (c * 3 + k) % 4;
      apply_prio();
      for (int a = 0; a < NE; a++) begin
        for (int b = 0; b < NE; b++) begin
          int w, o;
          w = a; o = b;
          if (lvl(b) < lvl(a) || (lvl(b) == lvl(a) && b < a)) begin w = b; o = a; end
          sw_set_pend = '0;
          sw_set_pend[a] = 1'b1;
          sw_set_pend[b] = 1'b1;
          cyc();
          sw_set_pend = '0;
          chk_eq("R2", "pending after set", int'(exc_pending), (1 << a) | (1 << b));
          chk_eq("R3", "offer valid", int'(take_valid), 1);
          chk_eq("R3", "winner", int'(take_num), w);
          accept_one();
          chk_eq("R4", "active after accept", int'(exc_active), 1 << w);
          chk_eq("R4", "exec level", int'(exec_level), lvl(w));
          chk_eq("R3", "no equal-or-less urgent offer", int'(take_valid), 0);
          exit_one();
          chk_eq("R8", "level restored", int'(exec_level), IDLE);
          chk_eq("R9", "quiet after exit", int'(take_valid), 0);
          if (a != b) begin
            cyc();
            chk_eq("R3", "second offer", int'(take_valid), 1);
            chk_eq("R3", "second winner", int'(take_num), o);
            accept_one();
            exit_one();
          end
        end
      end
    end

    // R8 R6: four deep nesting
    for (int c = 0; c < NC; c++) prio_a[c] = 3;
    prio_a[6 - 2] = 1;
    apply_prio();
    cyc();
    irq_req[0] = 1; cyc(); irq_req[0] = 0;
    chk_eq("R8", "irq0 offered", int'(take_num), 7);
    accept_one();
    chk_eq("R8", "level irq0", int'(exec_level), 5);
    tick_zero = 1; cyc(); tick_zero = 0;
    chk_eq("R8", "tick preempts", int'(take_valid && take_num == 6), 1);
    accept_one();
    chk_eq("R8", "level tick", int'(exec_level), 3);
    hard_fault = 1; cyc(); hard_fault = 0;
    chk_eq("R6", "hard fault preempts", int'(take_valid && take_num == 1), 1);
    accept_one();
    nmi_req = 1; cyc(); nmi_req = 0;
    chk_eq("R6", "nmi preempts hard fault", int'(take_valid && take_num == 0), 1);
    accept_one();
    chk_eq("R8", "level nmi", int'(exec_level), 0);
    chk_eq("R8", "four active", int'(exc_active), (1 << 0) | (1 << 1) | (1 << 6) | (1 << 7));
    hard_fault = 1; cyc(); hard_fault = 0;
    chk_eq("R6", "nothing under nmi", int'(take_valid), 0);
    exit_one();
    chk_eq("R8", "back to hard fault", int'(exec_level), 1);
    cyc();
    chk_eq("R5", "same level not retaken", int'(take_valid), 0);
    exit_one();
    chk_eq("R10", "hf left pending only", int'(exc_pending[1] && !exc_active[1]), 1);
    chk_eq("R8", "back to tick", int'(exec_level), 3);
    cyc();
    chk_eq("R10", "hf offered again", int'(take_valid && take_num == 1), 1);
    accept_one();
    exit_one();
    exit_one();
    chk_eq("R8", "back to irq0", int'(exec_level), 5);
    exit_one();
    chk_eq("R8", "idle again", int'(exec_level), IDLE);

    // R5 R10: timer active and pending
    cyc();
    tick_zero = 1; cyc(); tick_zero = 0;
    accept_one();
    tick_zero = 1; cyc(); tick_zero = 0;
    chk_eq("R5", "active and pending", int'(exc_pending[6] && exc_active[6]), 1);
    chk_eq("R5", "not reoffered", int'(take_valid), 0);
    exit_one();
    chk_eq("R10", "pending only", int'(exc_pending[6] && !exc_active[6]), 1);
    chk_eq("R9", "quiet after exit", int'(take_valid), 0);
    cyc();
    chk_eq("R10", "reoffered", int'(take_valid && take_num == 6), 1);
    accept_one();
    exit_one();

    // R7: disabled debug monitor
    src_enable = '1;
    src_enable[4 - 2] = 1'b0;
    cyc();
    dbg_mon_req = 1; cyc(); dbg_mon_req = 0;
    repeat (3) cyc();
    chk_eq("R7", "disabled stays pending", int'(exc_pending[4]), 1);
    chk_eq("R7", "disabled not offered", int'(take_valid), 0);
    src_enable = '1;
    cyc();
    chk_eq("R7", "offered once enabled", int'(take_valid && take_num == 4), 1);
    accept_one();
    exit_one();

    // R6: fixed sources ignore enables
    src_enable = '0;
    cyc();
    hard_fault = 1; cyc(); hard_fault = 0;
    chk_eq("R6", "hard fault with enables off", int'(take_valid && take_num == 1), 1);
    accept_one();
    exit_one();

    // R11: exit with nothing active
    sw_set_pend[8] = 1'b1; cyc(); sw_set_pend = '0;
    chk_eq("R11", "masked irq1 waits", int'(take_valid), 0);
    handler_exit = 1; src_enable[8 - 2] = 1'b1; cyc(); handler_exit = 0;
    chk_eq("R11", "empty exit no quiet cycle", int'(take_valid && take_num == 8), 1);
    chk_eq("R11", "level unchanged", int'(exec_level), IDLE);
    chk_eq("R11", "pending kept", int'(exc_pending[8]), 1);
    accept_one();

    // R1: reset mid-flight clears active and pending
    sw_set_pend[3] = 1'b1; cyc(); sw_set_pend = '0;
    rst = 1; cyc(); rst = 0;
    chk_eq("R1", "pending cleared", int'(exc_pending), 0);
    chk_eq("R1", "active cleared", int'(exc_active), 0);
    chk_eq("R1", "level idle", int'(exec_level), IDLE);

    done = 1;
    summary();
    $finish;
  end
endmodule